// File: doc/BRIEF.md
# Capture/Reload Timer with Direction Control

A 16-bit timer/counter whose single external input pin serves one of three roles, selected by control bits: a falling edge either captures the running count, or clears the count, or the pin level steers the counting direction. Software owns three registers through a synchronous write/read port: a control word, a reload/capture register and the count value. The timer keeps two sticky event flags and combines them into one interrupt request line.

In up-only operation the count rolls from FFFFh to the reload value. In up/down operation the pin chooses the direction, and counting down past the reload value wraps the count to FFFFh. A clock-output enable input masks the overflow flag from the interrupt line, but the flag itself still sets. A PWM-enable input turns an external edge into a flag-only event.

Top module: `dir_cap_timer`

## Requirements
- R1: After reset the control word, reload register, count and read data are 0000h and irq_o is 0. Register addresses are 0 = control, 1 = reload/capture, 2 = count. reg_rdata_o shows the addressed register one clock after reg_addr_i is presented.
- R2: Control bit 2 is run. While it is 0 the count keeps its value.
- R3: With run set and control bit 4 clear, the count goes up by one per clock. From FFFFh it loads the reload value and sets the overflow flag, which is control bit 6.
- R4: With control bit 4 set, the count goes up while the synchronized pin is 1 and down while it is 0. The pin passes through a two-flop synchronizer. A down step taken while the count equals the reload value loads FFFFh and sets the overflow flag.
- R5: With control bit 0 = 1, bit 3 = 1 and bit 4 = 0, a falling pin edge copies the count into the reload register and sets the external flag, which is control bit 7. The count itself is unchanged.
- R6: With control bit 0 = 0, bit 3 = 1, bit 4 = 0 and pwm_en_i = 0, a falling pin edge sets the count to 0000h and sets the external flag.
- R7: With control bit 3 = 0, pin edges change neither the count, nor the reload register, nor the external flag.
- R8: With pwm_en_i = 1 in reload mode, a falling pin edge sets the external flag and leaves the count unchanged.
- R9: With control bit 4 set, the pin acts only as the direction input. Its edges cause no capture, no reload and no external flag.
- R10: The flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it as it is. If a hardware event and a software clear of the same flag fall in one cycle, the flag ends up set.
- R11: irq_o is control bit 1 AND'd with the OR of the two flags. The flags are also driven on ovf_flag_o and ext_flag_o.
- R12: While clk_out_en_i = 1, the overflow flag cannot raise irq_o, but it still sets. The external flag still raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| ext_pin_i | input | 1 | External event / direction pin (asynchronous) |
| pwm_en_i | input | 1 | PWM output active: edges only set the flag |
| clk_out_en_i | input | 1 | Clock-output mode: masks the overflow flag from irq_o |
| ovf_flag_o | output | 1 | Sticky overflow/underflow flag |
| ext_flag_o | output | 1 | Sticky external event flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: the counter's rollover setting the overflow flag, and a software write that clears that flag. The bench lets the count run from FFFEh so that the wrap lands exactly on the edge where the control write carrying a 0 in bit 6 takes effect. It then reads back the control word and expects the flag still set and the count reloaded and advanced. The run/halt write in that same cycle is checked as well: it must let that last increment happen.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned CTR_W  = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_COUNT  = 2'd2
  } reg_addr_e;

  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_IEN  = 1;
  localparam int unsigned B_RUN  = 2;
  localparam int unsigned B_XEN  = 3;
  localparam int unsigned B_DIR  = 4;
  localparam int unsigned B_OVF  = 6;
  localparam int unsigned B_EXT  = 7;

  typedef struct packed {
    logic dir_en;
    logic ext_en;
    logic run;
    logic irq_en;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/ctr_pin_sync.sv
module ctr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];

  // one fall pulse cannot repeat on the next cycle
  p_single_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         up_i,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_data_i,
  input  logic         zero_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  assign at_end = up_i ? (cnt_q == MAX) : (cnt_q == reload_i);
  assign wrap_o = run_i & ~sw_wr_i & ~zero_i & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (sw_wr_i)     cnt_d = sw_data_i;
    else if (zero_i) cnt_d = '0;
    else if (run_i) begin
      if (up_i) cnt_d = at_end ? reload_i : cnt_q + 1'b1;
      else      cnt_d = at_end ? MAX      : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  p_halt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sw_wr_i && !zero_i) |=> $stable(cnt_q));

  p_up_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && up_i && !sw_wr_i && !zero_i && cnt_q == MAX) |=> cnt_q == $past(reload_i));

  p_down_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !up_i && !sw_wr_i && !zero_i && cnt_q == reload_i) |=> cnt_q == MAX);

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i && !sw_wr_i) |=> cnt_q == '0);
endmodule

// File: rtl/ctr_ctrl_reg.sv
module ctr_ctrl_reg
  import ctr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ovf_set_i,
  input  logic          ext_set_i,
  output ctrl_t         ctrl_o,
  output logic          ovf_o,
  output logic          ext_o,
  output logic [DW-1:0] word_o
);
  ctrl_t ctrl_q;
  logic  ovf_q, ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        ctrl_q.cap_mode <= wdata_i[B_MODE];
        ctrl_q.irq_en   <= wdata_i[B_IEN];
        ctrl_q.run      <= wdata_i[B_RUN];
        ctrl_q.ext_en   <= wdata_i[B_XEN];
        ctrl_q.dir_en   <= wdata_i[B_DIR];
      end
      // writes only clear; hardware set wins
      ovf_q <= (ovf_q & ~(wr_i & ~wdata_i[B_OVF])) | ovf_set_i;
      ext_q <= (ext_q & ~(wr_i & ~wdata_i[B_EXT])) | ext_set_i;
    end
  end

  always_comb begin
    word_o         = '0;
    word_o[B_MODE] = ctrl_q.cap_mode;
    word_o[B_IEN]  = ctrl_q.irq_en;
    word_o[B_RUN]  = ctrl_q.run;
    word_o[B_XEN]  = ctrl_q.ext_en;
    word_o[B_DIR]  = ctrl_q.dir_en;
    word_o[B_OVF]  = ovf_q;
    word_o[B_EXT]  = ext_q;
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_q;
  assign ext_o  = ext_q;

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_i && !wdata_i[B_OVF])) |=> ovf_q);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_q);

  p_ext_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.ext_en && !ext_q) |=> !ext_q);
endmodule

// File: rtl/dir_cap_timer.sv
module dir_cap_timer
  import ctr_pkg::*;
#(
  parameter int unsigned W       = CTR_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  input  logic          ext_pin_i,
  input  logic          pwm_en_i,
  input  logic          clk_out_en_i,
  output logic          ovf_flag_o,
  output logic          ext_flag_o,
  output logic          irq_o
);
  ctrl_t        ctrl;
  logic [W-1:0] ctrl_word, cnt, reload_q, rdata_q;
  logic         pin_lvl, pin_fall, ext_evt, ext_zero, capture, wrap, up;
  logic         wr_ctrl, wr_reload, wr_cnt;

  assign wr_ctrl   = reg_we_i && reg_addr_i == AW'(A_CTRL);
  assign wr_reload = reg_we_i && reg_addr_i == AW'(A_RELOAD);
  assign wr_cnt    = reg_we_i && reg_addr_i == AW'(A_COUNT);

  ctr_pin_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .level_o(pin_lvl),
    .fall_o (pin_fall)
  );

  // pin drives events only when it is not the direction input
  assign ext_evt  = ctrl.ext_en & ~ctrl.dir_en & pin_fall;
  assign capture  = ext_evt & ctrl.cap_mode;
  assign ext_zero = ext_evt & ~ctrl.cap_mode & ~pwm_en_i;
  assign up       = ~ctrl.dir_en | pin_lvl;

  ctr_count_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .up_i     (up),
    .sw_wr_i  (wr_cnt),
    .sw_data_i(reg_wdata_i),
    .zero_i   (ext_zero),
    .reload_i (reload_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  ctr_ctrl_reg #(.DW(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_ctrl),
    .wdata_i  (reg_wdata_i),
    .ovf_set_i(wrap),
    .ext_set_i(ext_evt),
    .ctrl_o   (ctrl),
    .ovf_o    (ovf_flag_o),
    .ext_o    (ext_flag_o),
    .word_o   (ctrl_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        reload_q <= '0;
    else if (capture)   reload_q <= cnt;
    else if (wr_reload) reload_q <= reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else begin
      case (reg_addr_i)
        AW'(A_CTRL):   rdata_q <= ctrl_word;
        AW'(A_RELOAD): rdata_q <= reload_q;
        AW'(A_COUNT):  rdata_q <= cnt;
        default:       rdata_q <= '0;
      endcase
    end
  end
  assign reg_rdata_o = rdata_q;

  assign irq_o = ctrl.irq_en & ((ovf_flag_o & ~clk_out_en_i) | ext_flag_o);

  p_irq_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_out_en_i && !ext_flag_o) |-> !irq_o);

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.irq_en |-> !irq_o);

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> reload_q == $past(cnt));

  p_dir_no_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.dir_en && !wr_reload) |=> $stable(reload_q));
endmodule

// File: tb/dir_cap_timer_bench.sv
module dir_cap_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        pin = 1'b0, pwm = 1'b0, cko = 1'b0;
  logic        ovf_f, ext_f, irq;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dir_cap_timer u_dir_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_pin_i(pin),
    .pwm_en_i(pwm), .clk_out_en_i(cko), .ovf_flag_o(ovf_f),
    .ext_flag_o(ext_f), .irq_o(irq)
  );

  // monitor: compare registered read data after the edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic fall_edge();
    pin = 1'b1; idle(4);
    pin = 1'b0; idle(5);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_bit(irq, 1'b0, "R1 irq after reset");
    rd(2'd0, 16'h0000, "R1 ctrl reset");
    rd(2'd1, 16'h0000, "R1 reload reset");
    rd(2'd2, 16'h0000, "R1 count reset");

    // R2 halted count holds
    wr(2'd2, 16'h0005);
    idle(10);
    rd(2'd2, 16'h0005, "R2 halt holds count");

    // R3 up count with rollover to reload value
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'hFFFC);
    wr(2'd0, 16'h0004);
    idle(4);
    wr(2'd0, 16'h00C0);
    rd(2'd2, 16'h1235, "R3 rollover loads reload");
    rd(2'd0, 16'h0040, "R3 overflow flag set");

    // R11/R12 interrupt gating
    wr(2'd0, 16'h0042);
    chk_bit(irq, 1'b1, "R11 irq from overflow flag");
    cko = 1'b1; idle(1);
    chk_bit(irq, 1'b0, "R12 clock-output masks overflow");
    chk_bit(ovf_f, 1'b1, "R12 flag still set");
    cko = 1'b0;

    // R10 write 0 clears
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0000, "R10 flag cleared by write 0");

    // R4 down count with underflow wrap
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h0012);
    pin = 1'b0; idle(3);
    wr(2'd0, 16'h0014);
    idle(3);
    wr(2'd0, 16'h00D0);
    rd(2'd2, 16'hFFFE, "R4 down wrap to FFFF then down");
    rd(2'd0, 16'h0050, "R4 underflow flag");

    // R4 up while pin high in direction mode
    wr(2'd2, 16'h0100);
    pin = 1'b1; idle(3);
    wr(2'd0, 16'h0014);
    idle(2);
    wr(2'd0, 16'h00D0);
    rd(2'd2, 16'h0103, "R4 up with pin high");

    // R10 hardware set wins against same-cycle clear
    wr(2'd1, 16'h0055);
    wr(2'd2, 16'hFFFE);
    wr(2'd0, 16'h0044);
    idle(1);
    wr(2'd0, 16'h0004);
    wr(2'd0, 16'h0040);
    rd(2'd0, 16'h0040, "R10 set wins over clear");
    rd(2'd2, 16'h0056, "R10 count reloaded in same cycle");

    // R5 capture
    wr(2'd0, 16'h0009);
    wr(2'd2, 16'h4321);
    fall_edge();
    rd(2'd1, 16'h4321, "R5 capture into reload register");
    rd(2'd2, 16'h4321, "R5 count unchanged");
    rd(2'd0, 16'h0089, "R5 external flag");

    // R6 edge reload clears count
    wr(2'd0, 16'h0008);
    wr(2'd2, 16'h0777);
    fall_edge();
    rd(2'd2, 16'h0000, "R6 edge zeroes count");
    rd(2'd0, 16'h0088, "R6 external flag");

    // R7 external disabled
    wr(2'd2, 16'h0999);
    wr(2'd0, 16'h0000);
    fall_edge();
    rd(2'd2, 16'h0999, "R7 count ignored edge");
    rd(2'd1, 16'h4321, "R7 reload ignored edge");
    rd(2'd0, 16'h0000, "R7 no external flag");

    // R8 PWM active: flag only
    pwm = 1'b1;
    wr(2'd0, 16'h0008);
    fall_edge();
    rd(2'd2, 16'h0999, "R8 no reload with pwm");
    rd(2'd0, 16'h0088, "R8 external flag with pwm");
    pwm = 1'b0;

    // R12 external flag not masked
    cko = 1'b1;
    wr(2'd0, 16'h0082);
    chk_bit(irq, 1'b1, "R12 external flag raises irq");
    wr(2'd0, 16'h0080);
    chk_bit(irq, 1'b0, "R11 irq disabled");
    cko = 1'b0;

    // R9 direction mode ignores edges
    wr(2'd0, 16'h0018);
    wr(2'd2, 16'h0AAA);
    fall_edge();
    rd(2'd2, 16'h0AAA, "R9 no reload in direction mode");
    rd(2'd0, 16'h0018, "R9 no flag in direction mode");
    chk_bit(ext_f, 1'b0, "R9 ext flag port");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule